// File: doc/BRIEF.md
# Multi-Channel Match Timer Bank with Safe Count Snapshot

This block holds a bank of up-counting timers that run on a counter clock unrelated to the bus clock. Every timer owns a count, a preload value and a set of match comparators. A per-timer reload mask picks which comparators, on a hit, make the counter take its preload value at the next counter edge. This gives a counting window that repeats. With an empty mask the counter runs free and wraps at its full width. One enable register starts and freezes the timers, one bit each.

Software never reads a live count. It writes a request to a timer's capture register. The request crosses into the counter domain, which latches the count into a holding register. An acknowledge crosses back, and the bus side copies the held value into the capture register. Until that copy happens the capture register keeps its earlier value, so a read never sees a count that is half updated. Writing a timer's count address loads a new count into the counter through the same kind of crossing.

Configuration registers (match, preload, reload mask) are read directly by the counter domain. Software changes them only while the timer is stopped. Reset is asynchronous and active low for both domains.

Top module: `mtimer_bank`

## Requirements
- R1: After reset every register reads 0: clock select, all match, preload and reload-mask registers, the enable register and every capture register.
- R2: Word address map with the default parameters: 0 is clock select (bit 0), 1+3t+c is match comparator c of timer t, 10+t is the count of timer t, 13+t its preload, 16+t its reload mask (bit c selects comparator c), 19 the enable register (bit t for timer t), and 20+t its capture register. Match, preload, reload-mask, enable and clock-select values read back as written.
- R3: Setting enable bit t makes timer t count. Timers whose bit is clear keep their count.
- R4: While enabled, with no reload and no load, the count rises by exactly one on every counter-clock edge, so no count is skipped or repeated.
- R5: When an enabled counter equals the match value of comparator c and mask bit c is set, the next counter edge sets the count to the preload value. Comparators whose mask bit is clear never reload.
- R6: With match 0xFFFFFFFF selected and preload 0, or with an empty mask, the counter goes from all ones to 0 and keeps counting.
- R7: Clearing a timer's enable bit freezes its count. Setting it again resumes counting from the frozen value.
- R8: Writing the count address of timer t loads the written value into that counter whether it is enabled or not. Reading the count address returns the timer's capture register.
- R9: Writing 1 in bit 0 of capture register t requests a snapshot. The register keeps its previous value until the snapshot completes, within 30 bus cycles, and then holds the count taken in the counter domain. A write with bit 0 clear requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cnt_clk | input | 1 | Counter clock, unrelated to the bus clock |
| bus_wr | input | 1 | Write strobe, one bus cycle per write |
| bus_addr | input | 6 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two pairs of operations can land on the same counter-clock edge. A snapshot request can meet a count load, and a snapshot can meet a reload. For the first pair, the bench writes a load and a snapshot request in consecutive bus cycles. It accepts only the count from just before the load or the newly loaded value, never anything else. For the second pair, the bench takes repeated snapshots of timers running in short reload windows. Some of these fall on the reload edge. Each one must lie between the preload and the selected match value, while internal properties check the count on the edge after each hit.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

   typedef enum logic [2:0] {
      REG_CLK,
      REG_MATCH,
      REG_COUNT,
      REG_PRE,
      REG_MASK,
      REG_EN,
      REG_CAP,
      REG_NONE
   } mtb_reg_e;

   typedef struct packed {
      mtb_reg_e   kind;
      logic [7:0] idx;
   } mtb_dec_t;

   // number of word registers for a given bank shape
   function automatic int unsigned mtb_reg_total(input int unsigned nt, input int unsigned nc);
      return 2 + nt * nc + 4 * nt;
   endfunction

   // address decode: clock select, matches, counts, preloads, masks, enable, captures
   function automatic mtb_dec_t mtb_decode(input int unsigned a,
                                           input int unsigned nt,
                                           input int unsigned nc);
      mtb_dec_t    d;
      int unsigned b_match, b_count, b_pre, b_mask, b_en, b_cap;
      b_match = 1;
      b_count = b_match + nt * nc;
      b_pre   = b_count + nt;
      b_mask  = b_pre + nt;
      b_en    = b_mask + nt;
      b_cap   = b_en + 1;
      d.kind  = REG_NONE;
      d.idx   = '0;
      if (a == 0) begin
         d.kind = REG_CLK;
      end else if (a < b_count) begin
         d.kind = REG_MATCH;
         d.idx  = 8'(a - b_match);
      end else if (a < b_pre) begin
         d.kind = REG_COUNT;
         d.idx  = 8'(a - b_count);
      end else if (a < b_mask) begin
         d.kind = REG_PRE;
         d.idx  = 8'(a - b_pre);
      end else if (a < b_en) begin
         d.kind = REG_MASK;
         d.idx  = 8'(a - b_mask);
      end else if (a == b_en) begin
         d.kind = REG_EN;
      end else if (a < b_cap + nt) begin
         d.kind = REG_CAP;
         d.idx  = 8'(a - b_cap);
      end
      return d;
   endfunction

endpackage

// File: rtl/mtb_toggle_sync.sv
module mtb_toggle_sync #(
   parameter int STAGES = 2
) (
   input  logic src_clk,
   input  logic dst_clk,
   input  logic rst_n,
   input  logic src_pulse,
   output logic dst_pulse
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mtb_toggle_sync: STAGES must be at least 2");
      end
   endgenerate

   logic            src_tgl;
   logic [STAGES:0] dst_sh;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n)         src_tgl <= 1'b0;
      else if (src_pulse) src_tgl <= ~src_tgl;
   end

   always_ff @(posedge dst_clk or negedge rst_n) begin
      if (!rst_n) dst_sh <= '0;
      else        dst_sh <= {dst_sh[STAGES-1:0], src_tgl};
   end

   assign dst_pulse = dst_sh[STAGES] ^ dst_sh[STAGES-1];

endmodule

// File: rtl/mtb_channel.sv
module mtb_channel #(
   parameter int CNT_W       = 32,
   parameter int N_CMP       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   cnt_clk,
   input  logic                   rst_n,
   input  logic                   en_async,
   input  logic                   load_pulse,
   input  logic [CNT_W-1:0]       load_val,
   input  logic [CNT_W-1:0]       preload,
   input  logic [N_CMP-1:0]       reload_mask,
   input  logic [N_CMP*CNT_W-1:0] match_vec,
   input  logic                   snap_pulse,
   output logic [CNT_W-1:0]       hold_val
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mtb_channel: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] en_sh;
   logic                   en_s;
   logic [CNT_W-1:0]       count_q;
   logic [N_CMP-1:0]       hit;
   logic                   reload;

   always_ff @(posedge cnt_clk or negedge rst_n) begin
      if (!rst_n) en_sh <= '0;
      else        en_sh <= {en_sh[SYNC_STAGES-2:0], en_async};
   end
   assign en_s = en_sh[SYNC_STAGES-1];

   genvar c;
   generate
      for (c = 0; c < N_CMP; c++) begin : g_cmp
         assign hit[c] = (count_q == match_vec[c*CNT_W +: CNT_W]);

         assert_reload_R5: assert property (@(posedge cnt_clk) disable iff (!rst_n)
            (en_s && !load_pulse && reload_mask[c] &&
             count_q == match_vec[c*CNT_W +: CNT_W])
            |=> (count_q == $past(preload)));
      end
   endgenerate

   assign reload = |(hit & reload_mask);

   always_ff @(posedge cnt_clk or negedge rst_n) begin
      if (!rst_n)          count_q <= '0;
      else if (load_pulse) count_q <= load_val;
      else if (en_s)       count_q <= reload ? preload : count_q + 1'b1;
   end

   always_ff @(posedge cnt_clk or negedge rst_n) begin
      if (!rst_n)          hold_val <= '0;
      else if (snap_pulse) hold_val <= count_q;
   end

   assert_step_one_R4: assert property (@(posedge cnt_clk) disable iff (!rst_n)
      (en_s && !load_pulse && !reload) |=> (count_q == $past(count_q) + 1'b1));

   assert_frozen_R7: assert property (@(posedge cnt_clk) disable iff (!rst_n)
      (!en_s && !load_pulse) |=> $stable(count_q));

endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
   import mtb_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int N_TMR       = 3,
   parameter int N_CMP       = 3,
   parameter int ADDR_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_clk,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata
);

   localparam int N_MATCH   = N_TMR * N_CMP;
   localparam int REG_TOTAL = int'(mtb_reg_total(N_TMR, N_CMP));

   generate
      if (REG_TOTAL > (1 << ADDR_W)) begin : g_bad_addr
         $error("mtimer_bank: ADDR_W too small for the register count");
      end
      if (N_TMR > CNT_W || N_CMP > CNT_W) begin : g_bad_width
         $error("mtimer_bank: timer or comparator count exceeds data width");
      end
      if (N_TMR > 255 || N_MATCH > 255) begin : g_bad_index
         $error("mtimer_bank: index field too narrow");
      end
   endgenerate

   mtb_dec_t dec;
   assign dec = mtb_decode(32'(bus_addr), N_TMR, N_CMP);

   logic                   clk_sel_q;
   logic [CNT_W-1:0]       match_q [N_MATCH];
   logic [CNT_W-1:0]       pre_q   [N_TMR];
   logic [CNT_W-1:0]       load_q  [N_TMR];
   logic [CNT_W-1:0]       cap_q   [N_TMR];
   logic [CNT_W-1:0]       hold_w  [N_TMR];
   logic [N_CMP-1:0]       mask_q  [N_TMR];
   logic [N_TMR-1:0]       en_q;
   logic [N_TMR-1:0]       wr_load, wr_snap, load_c, snap_c, ack_b;
   logic [N_MATCH*CNT_W-1:0] match_flat;

   // ---------------- bus-side register file ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel_q <= 1'b0;
         en_q      <= '0;
         for (int i = 0; i < N_MATCH; i++) match_q[i] <= '0;
         for (int t = 0; t < N_TMR; t++) begin
            pre_q[t]  <= '0;
            load_q[t] <= '0;
            mask_q[t] <= '0;
         end
      end else if (bus_wr) begin
         if (dec.kind == REG_CLK) clk_sel_q <= bus_wdata[0];
         if (dec.kind == REG_EN)  en_q      <= bus_wdata[N_TMR-1:0];
         for (int i = 0; i < N_MATCH; i++)
            if (dec.kind == REG_MATCH && dec.idx == 8'(i)) match_q[i] <= bus_wdata;
         for (int t = 0; t < N_TMR; t++) begin
            if (dec.kind == REG_PRE   && dec.idx == 8'(t)) pre_q[t]  <= bus_wdata;
            if (dec.kind == REG_COUNT && dec.idx == 8'(t)) load_q[t] <= bus_wdata;
            if (dec.kind == REG_MASK  && dec.idx == 8'(t)) mask_q[t] <= bus_wdata[N_CMP-1:0];
         end
      end
   end

   // capture registers take the held count when the acknowledge returns
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int t = 0; t < N_TMR; t++) cap_q[t] <= '0;
      end else begin
         for (int t = 0; t < N_TMR; t++)
            if (ack_b[t]) cap_q[t] <= hold_w[t];
      end
   end

   always_comb begin
      for (int t = 0; t < N_TMR; t++) begin
         wr_load[t] = bus_wr && dec.kind == REG_COUNT && dec.idx == 8'(t);
         wr_snap[t] = bus_wr && dec.kind == REG_CAP && dec.idx == 8'(t) && bus_wdata[0];
      end
   end

   // ---------------- read multiplexer ----------------
   always_comb begin
      bus_rdata = '0;
      unique case (dec.kind)
         REG_CLK:  bus_rdata = CNT_W'(clk_sel_q);
         REG_EN:   bus_rdata = CNT_W'(en_q);
         REG_MATCH:
            for (int i = 0; i < N_MATCH; i++)
               if (dec.idx == 8'(i)) bus_rdata = match_q[i];
         REG_PRE:
            for (int t = 0; t < N_TMR; t++)
               if (dec.idx == 8'(t)) bus_rdata = pre_q[t];
         REG_MASK:
            for (int t = 0; t < N_TMR; t++)
               if (dec.idx == 8'(t)) bus_rdata = CNT_W'(mask_q[t]);
         REG_COUNT, REG_CAP:
            for (int t = 0; t < N_TMR; t++)
               if (dec.idx == 8'(t)) bus_rdata = cap_q[t];
         default:  bus_rdata = '0;
      endcase
   end

   // ---------------- per-timer channels ----------------
   genvar g, t;
   generate
      for (g = 0; g < N_MATCH; g++) begin : g_flat
         assign match_flat[g*CNT_W +: CNT_W] = match_q[g];
      end

      for (t = 0; t < N_TMR; t++) begin : g_tmr
         mtb_toggle_sync #(.STAGES(SYNC_STAGES)) i_req_sync (
            .src_clk(clk), .dst_clk(cnt_clk), .rst_n(rst_n),
            .src_pulse(wr_snap[t]), .dst_pulse(snap_c[t]));

         mtb_toggle_sync #(.STAGES(SYNC_STAGES)) i_ack_sync (
            .src_clk(cnt_clk), .dst_clk(clk), .rst_n(rst_n),
            .src_pulse(snap_c[t]), .dst_pulse(ack_b[t]));

         mtb_toggle_sync #(.STAGES(SYNC_STAGES)) i_load_sync (
            .src_clk(clk), .dst_clk(cnt_clk), .rst_n(rst_n),
            .src_pulse(wr_load[t]), .dst_pulse(load_c[t]));

         mtb_channel #(.CNT_W(CNT_W), .N_CMP(N_CMP), .SYNC_STAGES(SYNC_STAGES)) i_chan (
            .cnt_clk    (cnt_clk),
            .rst_n      (rst_n),
            .en_async   (en_q[t]),
            .load_pulse (load_c[t]),
            .load_val   (load_q[t]),
            .preload    (pre_q[t]),
            .reload_mask(mask_q[t]),
            .match_vec  (match_flat[t*N_CMP*CNT_W +: N_CMP*CNT_W]),
            .snap_pulse (snap_c[t]),
            .hold_val   (hold_w[t]));

         assert_cap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !ack_b[t] |=> $stable(cap_q[t]));
      end
   endgenerate

endmodule

// File: tb/test_mtimer_bank.sv
`timescale 1ns/1ps
module test_mtimer_bank;

   logic        clk = 1'b0, cnt_clk = 1'b0, rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;
   always #6.5 cnt_clk = ~cnt_clk;

   mtimer_bank i_mtimer_bank (
      .clk(clk), .rst_n(rst_n), .cnt_clk(cnt_clk), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

   localparam int A_CLK = 0, A_MATCH = 1, A_CNT = 10, A_PRE = 13, A_MASK = 16,
                  A_EN = 19, A_CAP = 20;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input string exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=%s", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a); bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = 6'(a);
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic snap(input int t, output logic [31:0] d);
      wr(A_CAP + t, 32'h1);
      idle(30);
      rd(A_CAP + t, d);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      int a[] = '{A_CLK, A_MATCH, A_MATCH + 8, A_PRE + 2, A_MASK + 1, A_EN, A_CAP, A_CAP + 2, A_CNT};
      foreach (a[i]) begin
         rd(a[i], d);
         chk(d == 0, $sformatf("R1 reset addr %0d", a[i]), d, "0");
      end
   endtask

   task automatic t_readback;
      logic [31:0] d;
      wr(A_MATCH + 3*1 + 1, 32'hA5A5_1234);
      wr(A_PRE + 1, 32'h0000_0777);
      wr(A_MASK + 2, 32'h6);
      wr(A_CLK, 32'h1);
      rd(A_MATCH + 4, d); chk(d == 32'hA5A5_1234, "R2 match t1 c1", d, "a5a51234");
      rd(A_MATCH + 3, d); chk(d == 0, "R2 match t1 c0 untouched", d, "0");
      rd(A_PRE + 1, d);   chk(d == 32'h777, "R2 preload t1", d, "777");
      rd(A_MASK + 2, d);  chk(d == 32'h6, "R2 mask t2", d, "6");
      rd(A_CLK, d);       chk(d == 32'h1, "R2 clock select", d, "1");
      wr(A_CLK, 32'h0);
      rd(A_CLK, d);       chk(d == 32'h0, "R2 clock select back to 0", d, "0");
      wr(A_MATCH + 4, 32'h0); wr(A_PRE + 1, 32'h0); wr(A_MASK + 2, 32'h0);
   endtask

   task automatic t_load_capture;
      logic [31:0] d;
      wr(A_CNT, 32'd100); idle(30);
      snap(0, d); chk(d == 100, "R8 load then snapshot", d, "100");
      wr(A_CNT, 32'd200); idle(30);
      wr(A_CAP, 32'h1);
      rd(A_CAP, d); chk(d == 100, "R9 capture holds old value while pending", d, "100");
      idle(30);
      rd(A_CAP, d); chk(d == 200, "R9 capture after completion", d, "200");
      rd(A_CNT, d); chk(d == 200, "R8 count address returns capture", d, "200");
      wr(A_CNT, 32'd300); idle(30);
      wr(A_CAP, 32'h0); idle(60);
      rd(A_CAP, d); chk(d == 200, "R9 bit0 clear requests nothing", d, "200");
      wr(A_CNT, 32'd400);
      wr(A_CAP, 32'h1); idle(30);
      rd(A_CAP, d); chk(d == 300 || d == 400, "R9 load and snapshot together", d, "300 or 400");
   endtask

   task automatic t_freeze_resume;
      logic [31:0] a, b, c;
      wr(A_CNT, 32'd1000); idle(30);
      wr(A_EN, 32'h1); idle(100);
      wr(A_EN, 32'h0); idle(10);
      snap(0, a);
      chk(a > 1010 && a <= 1045, "R3/R4 counting while enabled", a, "1011..1045");
      idle(40);
      snap(0, b); chk(b == a, "R7 frozen after disable", b, $sformatf("%0d", a));
      wr(A_EN, 32'h1); idle(100);
      wr(A_EN, 32'h0); idle(10);
      snap(0, c);
      chk(c - a >= 20 && c - a <= 45, "R7 resume from frozen value", c,
          $sformatf("%0d..%0d", a + 20, a + 45));
   endtask

   task automatic t_reload_windows;
      logic [31:0] d, f0, f1;
      // timer 1: comparator 0 match 9, preload 5
      wr(A_CNT + 1, 32'd0); idle(30);
      wr(A_MATCH + 3, 32'd9); wr(A_PRE + 1, 32'd5); wr(A_MASK + 1, 32'h1);
      snap(0, f0);
      wr(A_EN, 32'h2); idle(60);
      for (int k = 0; k < 8; k++) begin
         snap(1, d); idle(k);
         chk(d >= 5 && d <= 9, "R5 timer1 stays in preload..match window", d, "5..9");
      end
      snap(0, d); chk(d == f0, "R3 timer0 idle while timer1 runs", d, $sformatf("%0d", f0));
      // timer 2: comparator 0 at 3 not selected, comparator 1 at 20 selected
      wr(A_EN, 32'h0); idle(10);
      snap(1, f1);
      wr(A_CNT + 2, 32'd11); idle(30);
      wr(A_MATCH + 6, 32'd3); wr(A_MATCH + 7, 32'd20);
      wr(A_PRE + 2, 32'd10); wr(A_MASK + 2, 32'h2);
      wr(A_EN, 32'h4); idle(60);
      for (int k = 0; k < 8; k++) begin
         snap(2, d); idle(2 * k);
         chk(d >= 10 && d <= 20, "R5 unselected comparator ignored, window 10..20", d, "10..20");
      end
      snap(1, d); chk(d == f1, "R3 timer1 frozen while timer2 runs", d, $sformatf("%0d", f1));
      wr(A_EN, 32'h0); idle(10);
   endtask

   task automatic t_wrap;
      logic [31:0] d;
      wr(A_CNT, 32'hFFFF_FFF0); idle(30);
      wr(A_MATCH, 32'hFFFF_FFFF); wr(A_PRE, 32'h0); wr(A_MASK, 32'h1);
      wr(A_EN, 32'h1); idle(80);
      wr(A_EN, 32'h0); idle(10);
      snap(0, d); chk(d < 64, "R6 wrap through all ones to 0 (selected match)", d, "<64");
      wr(A_MASK, 32'h0);
      wr(A_CNT, 32'hFFFF_FFF0); idle(30);
      wr(A_EN, 32'h1); idle(80);
      wr(A_EN, 32'h0); idle(10);
      snap(0, d); chk(d < 64, "R6 free-running wrap with empty mask", d, "<64");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      idle(4);
      t_reset();
      t_readback();
      t_load_capture();
      t_freeze_resume();
      t_reload_windows();
      t_wrap();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0x%08h expected=completion", 32'h0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule